// File: doc/BRIEF.md
# Clock divider and peripheral gating controller

This block is a register-mapped controller for the system clocks. A free-running counter on the reference clock produces three divided clock-enable strobes, one each for the processor, main-interconnect and peripheral-bus clocks. Each strobe divides the reference by a power of two that is chosen by a 2-bit code. Codes written by software are held as pending values. They are applied to the strobes only at the counter wrap, where every derived clock is at a common period boundary, so a ratio change never produces a short pulse.

The block also keeps a 32-bit peripheral clock-enable register and a 32-bit peripheral hold-in-reset register. Both drive output vectors directly. A derived status vector reports which peripherals are actually running. A single-cycle write strobe and a combinational read port give access to all three registers.

Top module: `sysclk_ctrl`

## Requirements
- R1: The divider-code register is at byte offset 0x08, the clock-enable register at 0x84 and the hold-in-reset register at 0x88. A write with `bus_wr` high takes effect at the next rising edge. `bus_rdata` shows the addressed register in the same cycle. Any other offset reads as zero, and a write to it changes no register.
- R2: In the divider-code register, bits [1:0] hold the processor code, bits [3:2] the interconnect code and bits [5:4] the peripheral-bus code. Bits [31:6] read as zero. After reset the register reads 0x10.
- R3: `div_ce[0]`, `div_ce[1]` and `div_ce[2]` belong to the processor, interconnect and peripheral-bus clocks. A 3-bit counter is zero while reset is held and advances by one (mod 8) at every rising edge with `rst_n` high. A strobe is high exactly in the cycles where the counter is a multiple of 2 raised to its active code, so codes 0..3 divide by 1, 2, 4 and 8.
- R4: A code of 0 written to the peripheral-bus field is stored as 1 (divide by 2) and reads back as 1. The other two fields store every code unchanged.
- R5: A written code becomes active only at the rising edge where the counter wraps from 7 to 0. In the cycle where the counter is 0, all three strobes are high.
- R6: Peripheral bits 0..29 exist except bit 17. Bits 17, 30 and 31 of both peripheral registers read as zero, ignore writes and are zero on the outputs.
- R7: `periph_run[i]` is high exactly when clock-enable bit i is 1 and hold-in-reset bit i is 0.
- R8: Reset affects the critical bits 0, 5 and 23..27 and the other existing bits differently. The critical bits come out with clock enabled and hold released. Every other existing bit comes out with clock disabled and hold asserted.
- R9: `periph_clk_en` and `periph_rst` always equal the values read back at 0x84 and 0x88.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| div_ce | output | 3 | Divided clock-enable strobes: processor, interconnect, peripheral bus |
| periph_clk_en | output | 32 | Per-peripheral clock enables |
| periph_rst | output | 32 | Per-peripheral active-high resets |
| periph_run | output | 32 | Peripherals that are enabled and out of reset |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are known whenever `bus_wr` is high. They also assume that reset is held for at least one rising edge before it is released, so the counter and the active codes start from their reset values. The stimulus drives every input at the falling edge and never leaves an input unknown after time zero. The code sweep writes all 64 divider settings, with the upper bits filled with ones. It always lets at least one full counter wrap pass, so that both the pending and the active ratio are observed.

// File: rtl/sysclk_pkg.sv
// Shared constants for the system clock controller: register offsets,
// field sizes, the existing and critical peripheral bit sets, and the
// lowest legal divider code of each derived clock.
package sysclk_pkg;

    localparam int REG_W       = 32;
    localparam int ADDR_W      = 8;
    localparam int NCLK        = 3;
    localparam int CODE_W      = 2;
    localparam int PERIPH_N    = 30;
    localparam int PERIPH_HOLE = 17;

    localparam int CLK_CPU = 0;
    localparam int CLK_AXI = 1;
    localparam int CLK_AHB = 2;

    localparam logic [ADDR_W-1:0] OFS_DIVCFG = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CKEN   = 8'h84;
    localparam logic [ADDR_W-1:0] OFS_HOLD   = 8'h88;

    // Bits that correspond to a real peripheral.
    function automatic logic [REG_W-1:0] live_mask();
        logic [REG_W-1:0] m;
        for (int i = 0; i < REG_W; i++) begin
            m[i] = (i < PERIPH_N) && (i != PERIPH_HOLE);
        end
        return m;
    endfunction

    // Peripherals that must run straight out of reset.
    function automatic logic [REG_W-1:0] crit_mask();
        logic [REG_W-1:0] m;
        m    = '0;
        m[0] = 1'b1;
        m[5] = 1'b1;
        for (int i = 23; i <= 27; i++) begin
            m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] LIVE_MASK = live_mask();
    localparam logic [REG_W-1:0] CRIT_MASK = crit_mask();

    // Lowest code each derived clock accepts.
    function automatic logic [CODE_W-1:0] floor_code(int idx);
        return (idx == CLK_AHB) ? CODE_W'(1) : CODE_W'(0);
    endfunction

    // Reset value of the packed divider-code field: every clock at its floor.
    function automatic logic [NCLK*CODE_W-1:0] cfg_reset();
        logic [NCLK*CODE_W-1:0] v;
        for (int i = 0; i < NCLK; i++) begin
            v[i*CODE_W +: CODE_W] = floor_code(i);
        end
        return v;
    endfunction

    localparam logic [NCLK*CODE_W-1:0] CFG_RESET = cfg_reset();

endpackage

// File: rtl/sysclk_regs.sv
// Register file of the clock controller.
// Holds the pending divider codes, the clock-enable vector and the
// hold-in-reset vector. Writes land on the rising edge after bus_wr.
// Reads are combinational on bus_addr.
// Assumes: addr and wdata are stable and known whenever wr is high.
module sysclk_regs
    import sysclk_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int AW = ADDR_W,
    parameter int NC = NCLK,
    parameter int CW = CODE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    rdata,
    output logic [NC*CW-1:0] div_cfg,
    output logic [W-1:0]    cken,
    output logic [W-1:0]    hold
);

    localparam logic [W-1:0] LIVE     = W'(LIVE_MASK);
    localparam logic [W-1:0] CRIT     = W'(CRIT_MASK);
    localparam logic [W-1:0] CKEN_RST = CRIT & LIVE;
    localparam logic [W-1:0] HOLD_RST = LIVE & ~CRIT;

    logic [NC*CW-1:0] cfg_legal;

    // Raise any code below its clock's floor up to that floor.
    always_comb begin
        for (int i = 0; i < NC; i++) begin
            cfg_legal[i*CW +: CW] = (wdata[i*CW +: CW] < floor_code(i))
                                    ? floor_code(i) : wdata[i*CW +: CW];
        end
    end

    // Register update from the write port, reset to the power-on image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cfg <= CFG_RESET;
            cken    <= CKEN_RST;
            hold    <= HOLD_RST;
        end else if (wr) begin
            unique case (addr)
                AW'(OFS_DIVCFG): div_cfg <= cfg_legal;
                AW'(OFS_CKEN):   cken    <= wdata & LIVE;
                AW'(OFS_HOLD):   hold    <= wdata & LIVE;
                default: ;
            endcase
        end
    end

    // Readback mux; unmapped offsets return zero.
    always_comb begin
        unique case (addr)
            AW'(OFS_DIVCFG): rdata = W'(div_cfg);
            AW'(OFS_CKEN):   rdata = cken;
            AW'(OFS_HOLD):   rdata = hold;
            default:         rdata = '0;
        endcase
    end

endmodule

// File: rtl/sysclk_divgen.sv
// Divided clock-enable generator.
// A free-running counter of 2**CW-1 bits spans the largest ratio.
// Pending codes are copied to the active set only when the counter is
// all ones, so every new ratio starts on the common period boundary.
// Assumes: div_cfg only holds legal codes.
module sysclk_divgen #(
    parameter int NC = 3,
    parameter int CW = 2,
    parameter logic [NC*CW-1:0] ACT_INIT = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NC*CW-1:0]        div_cfg,
    output logic [(1<<CW)-2:0]      cnt,
    output logic [NC-1:0]           ce
);

    localparam int CNT_W = (1 << CW) - 1;

    logic [NC*CW-1:0] act;

    // Shared phase counter on the reference clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CNT_W'(1);
    end

    // Adopt pending codes at the wrap edge only.
    always_ff @(posedge clk) begin
        if (!rst_n)    act <= ACT_INIT;
        else if (&cnt) act <= div_cfg;
    end

    // One strobe per derived clock: high when the low code bits of the counter are zero.
    for (genvar g = 0; g < NC; g++) begin : g_strobe
        logic [CNT_W-1:0] sel_mask;
        assign sel_mask = ~({CNT_W{1'b1}} << act[g*CW +: CW]);
        assign ce[g]    = ((cnt & sel_mask) == '0);
    end

endmodule

// File: rtl/sysclk_runstat.sv
// Running-status decode: a peripheral runs when its clock is enabled
// and its reset is released. Bits without a peripheral stay zero.
module sysclk_runstat #(
    parameter int W = 32,
    parameter logic [W-1:0] LIVE = '1
) (
    input  logic [W-1:0] cken,
    input  logic [W-1:0] hold,
    output logic [W-1:0] run
);

    // Combine the two registers per bit.
    assign run = cken & ~hold & LIVE;

endmodule

// File: rtl/sysclk_ctrl.sv
// System clock controller top: register file, divider strobe generator
// and running-status decode.
// Assumes: one reference clock domain, synchronous active-low reset.
module sysclk_ctrl
    import sysclk_pkg::*;
(
    input  logic        clk_ref,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [2:0]  div_ce,
    output logic [31:0] periph_clk_en,
    output logic [31:0] periph_rst,
    output logic [31:0] periph_run
);

    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [NCLK*CODE_W-1:0] div_cfg;
    logic [CNT_W-1:0]       div_cnt;

    sysclk_regs #(
        .W (REG_W),
        .AW(ADDR_W),
        .NC(NCLK),
        .CW(CODE_W)
    ) u_regs (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .div_cfg(div_cfg),
        .cken   (periph_clk_en),
        .hold   (periph_rst)
    );

    sysclk_divgen #(
        .NC      (NCLK),
        .CW      (CODE_W),
        .ACT_INIT(CFG_RESET)
    ) u_divgen (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .div_cfg(div_cfg),
        .cnt    (div_cnt),
        .ce     (div_ce)
    );

    sysclk_runstat #(
        .W   (REG_W),
        .LIVE(LIVE_MASK)
    ) u_runstat (
        .cken(periph_clk_en),
        .hold(periph_rst),
        .run (periph_run)
    );

endmodule

// File: rtl/sysclk_ctrl_chk.sv
// Property checker for sysclk_ctrl, attached with bind below.
module sysclk_ctrl_chk
    import sysclk_pkg::*;
(
    input logic        clk_ref,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic [2:0]  div_ce,
    input logic [2:0]  div_cnt,
    input logic [31:0] periph_clk_en,
    input logic [31:0] periph_rst,
    input logic [31:0] periph_run
);

    // R4
    ahb_code_legal_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (bus_addr == OFS_DIVCFG) |-> (bus_rdata[5:4] != 2'd0));

    // R5
    wrap_all_high_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (div_cnt == 3'd0) |-> (div_ce == 3'b111));

    // R3
    cnt_step_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(rst_n) |-> (div_cnt == 3'($past(div_cnt) + 3'd1)));

    // R6
    no_phantom_bits_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((periph_clk_en | periph_rst | periph_run) & ~LIVE_MASK) == 32'd0);

    // R7
    run_needs_clock_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((periph_run & ~periph_clk_en) | (periph_run & periph_rst)) == 32'd0);

    // R8
    crit_after_reset_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(!rst_n) |-> ((periph_clk_en & CRIT_MASK) == CRIT_MASK));

endmodule

bind sysclk_ctrl sysclk_ctrl_chk u_chk (
    .clk_ref      (clk_ref),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .div_ce       (div_ce),
    .div_cnt      (div_cnt),
    .periph_clk_en(periph_clk_en),
    .periph_rst   (periph_rst),
    .periph_run   (periph_run)
);

// File: tb/sysclk_ctrl_bench.sv
// Bench for sysclk_ctrl: sweeps every divider setting and walks every
// peripheral bit, computing expected values from the requirements.
module sysclk_ctrl_bench;

    localparam int PERIOD = 10;
    localparam logic [31:0] LIVE = 32'h3FFD_FFFF;
    localparam logic [31:0] CRIT = 32'h0F80_0021;

    logic        clk_ref = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [2:0]  div_ce;
    logic [31:0] periph_clk_en, periph_rst, periph_run;

    int n_chk = 0;
    int n_err = 0;
    bit track = 1'b0;
    bit done = 1'b0;

    // Arithmetic model of the divider timing from R3, R4, R5.
    logic [2:0] m_cnt;
    logic [5:0] m_cfg, m_act;

    always #(PERIOD/2) clk_ref = ~clk_ref;

    sysclk_ctrl u_sysclk_ctrl (
        .clk_ref(clk_ref), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_ce(div_ce),
        .periph_clk_en(periph_clk_en), .periph_rst(periph_rst), .periph_run(periph_run)
    );

    function automatic logic [5:0] legal(logic [5:0] v);
        return (v[5:4] == 2'd0) ? (v | 6'h10) : v;
    endfunction

    always @(posedge clk_ref) begin
        if (!rst_n) begin
            m_cnt <= 3'd0;
            m_cfg <= 6'h10;
            m_act <= 6'h10;
        end else begin
            m_cnt <= m_cnt + 3'd1;
            if (m_cnt == 3'd7) m_act <= m_cfg;
            if (bus_wr && bus_addr == 8'h08) m_cfg <= legal(bus_wdata[5:0]);
        end
    end

    // R3 R5: strobe comparison on every falling edge.
    always @(negedge clk_ref) begin
        if (track) begin
            logic [2:0] exp_ce;
            for (int i = 0; i < 3; i++) begin
                int code;
                code = int'(m_act[2*i +: 2]);
                exp_ce[i] = ((int'(m_cnt) % (1 << code)) == 0);
            end
            n_chk++;
            if (div_ce !== exp_ce) begin
                n_err++;
                $display("FAIL R3/R5 div_ce cnt=%0d act=%h: got %b exp %b",
                         m_cnt, m_act, div_ce, exp_ce);
            end
        end
    end

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h exp %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk_ref);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk_ref);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic read_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check32(tag, bus_rdata, exp);
    endtask

    task automatic periph_check(input string tag, input logic [31:0] en, input logic [31:0] rs);
        read_check({tag, " R9 en readback"}, 8'h84, en);
        read_check({tag, " R9 rst readback"}, 8'h88, rs);
        check32({tag, " R6 en port"}, periph_clk_en, en);
        check32({tag, " R6 rst port"}, periph_rst, rs);
        check32({tag, " R7 run"}, periph_run, en & ~rs);
    endtask

    task automatic do_reset();
        @(negedge clk_ref);
        rst_n = 1'b0;
        repeat (3) @(negedge clk_ref);
        track = 1'b1;
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        do_reset();
        // R2 R8: power-on image.
        read_check("R2 cfg reset", 8'h08, 32'h10);
        periph_check("R8 reset", CRIT & LIVE, LIVE & ~CRIT);

        // R2 R4 R3 R5: all 64 codes, upper bits set to ones.
        for (int v = 0; v < 64; v++) begin
            bus_write(8'h08, {26'h3FF_FFFF, 6'(v)});
            read_check($sformatf("R2/R4 cfg code %0d", v), 8'h08,
                       {26'd0, legal(6'(v))});
            repeat (12 + (v % 5)) @(negedge clk_ref);
        end

        // R1: unmapped offsets read zero and leave the registers unchanged.
        bus_write(8'h08, 32'h0000_0039);
        bus_write(8'h84, 32'h1234_5678);
        bus_write(8'h88, 32'h0F0F_0F0F);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h80, 32'hFFFF_FFFF);
        bus_write(8'h00, 32'hFFFF_FFFF);
        read_check("R1 unmapped 0x0C", 8'h0C, 32'h0);
        read_check("R1 unmapped 0x8C", 8'h8C, 32'h0);
        read_check("R1 cfg kept", 8'h08, 32'h39);
        periph_check("R1 kept", 32'h1234_5678 & LIVE, 32'h0F0F_0F0F & LIVE);

        // R6 R7 R9: walk clock enables with resets released.
        bus_write(8'h88, 32'h0);
        for (int i = 0; i < 32; i++) begin
            bus_write(8'h84, 32'h1 << i);
            periph_check($sformatf("R6 en bit %0d", i), (32'h1 << i) & LIVE, 32'h0);
        end
        // Walk reset bits with all clocks enabled.
        bus_write(8'h84, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            bus_write(8'h88, 32'h1 << i);
            periph_check($sformatf("R7 rst bit %0d", i), LIVE, (32'h1 << i) & LIVE);
        end
        // Mixed patterns computed arithmetically.
        for (int k = 0; k < 8; k++) begin
            logic [31:0] a, b;
            a = 32'h9E37_79B9 * (k + 1);
            b = 32'h85EB_CA6B ^ (a >> 3);
            bus_write(8'h84, a);
            bus_write(8'h88, b);
            periph_check($sformatf("R7 pattern %0d", k), a & LIVE, b & LIVE);
        end

        // R8: reset in mid-run restores the image.
        do_reset();
        read_check("R8 cfg after rerun", 8'h08, 32'h10);
        periph_check("R8 rerun", CRIT & LIVE, LIVE & ~CRIT);
        repeat (20) @(negedge clk_ref);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule